// File: doc/BRIEF.md
# Line-Synchronous Clamp Pulse Generator

This block runs in the pixel clock domain and produces one clamp-enable pulse per video line. It brings the horizontal sync input into the clock domain through a two-flop synchronizer. A polarity select decides which level of that input counts as active. When the synchronized sync returns to its inactive level, the block counts off a programmable placement delay in pixel periods. It then holds its clamp output high for a programmable number of pixel periods.

Both settings are 8-bit counts. Their legal range is 1 to 255, and a value of zero is handled as 1. The block captures both settings at each trailing edge and keeps them for that line. A trailing edge that arrives while a sequence is still running cancels that sequence and starts a new placement count.

Top module: `hsync_clamp_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset is released, `clamp_out` is 0.
- R2: With `hs_low_act` = 0, sync is active when `hs_in` is 1. With `hs_low_act` = 1, sync is active when `hs_in` is 0. Only the change from the active level to the inactive level (the trailing edge) starts a sequence.
- R3: Let edge j be the first rising clock edge that samples `hs_in` at its inactive level after it has been active. `clamp_out` goes high right after edge j+2+N, where N is the captured placement.
- R4: `clamp_out` stays high for exactly M clock cycles, where M is the captured duration, and then returns low.
- R5: A placement of 0 behaves exactly as a placement of 1. A duration of 0 behaves exactly as a duration of 1.
- R6: `place_cfg` and `width_cfg` are sampled at edge j+2. Changes to them after that edge do not alter the current line's pulse.
- R7: A new trailing edge that is detected while a sequence is running aborts that sequence. `clamp_out` is low right after the detecting edge, and the placement count restarts from that edge.
- R8: The leading edge of sync (inactive to active) neither starts a sequence nor changes `clamp_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_in | input | 1 | Asynchronous horizontal sync |
| hs_low_act | input | 1 | 1 selects active-low sync |
| place_cfg | input | 8 | Placement delay N in pixel periods (0 handled as 1) |
| width_cfg | input | 8 | Clamp duration M in pixel periods (0 handled as 1) |
| clamp_out | output | 1 | Clamp enable |

## Verification
The bench measures the rise position and the width of the pulse against the point where the input deasserts. An off-by-one in the synchronizer latency or in either countdown would shift the pulse by a cycle or change its length. Zero settings are driven directly: a design that did not map zero to one would wrap its counter and produce a 256-cycle delay or pulse. Settings are changed in the middle of a line, which exposes a design that reads them live instead of capturing them. Sync lines short enough to retrigger during the placement wait or during the pulse, in both polarities, expose a design that ignores the new edge or starts the pulse on the leading edge.

// File: rtl/hsync_clamp_gen.sv
module hsync_clamp_gen #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_in,
  input  logic             hs_low_act,
  input  logic [CNT_W-1:0] place_cfg,
  input  logic [CNT_W-1:0] width_cfg,
  output logic             clamp_out
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ON} phase_t;

  logic             sy1, sy2, sy3;
  logic             trail;
  phase_t           phase;
  logic [CNT_W-1:0] cnt, width_lat;
  logic [CNT_W-1:0] place_eff, width_eff;

  assign place_eff = (place_cfg == '0) ? ONE : place_cfg;
  assign width_eff = (width_cfg == '0) ? ONE : width_cfg;
  assign trail     = sy3 & ~sy2;
  assign clamp_out = (phase == ST_ON);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy1 <= 1'b0;
      sy2 <= 1'b0;
      sy3 <= 1'b0;
    end else begin
      sy1 <= hs_in ^ hs_low_act;
      sy2 <= sy1;
      sy3 <= sy2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= ST_IDLE;
      cnt       <= '0;
      width_lat <= ONE;
    end else if (trail) begin
      phase     <= ST_WAIT;
      cnt       <= place_eff;
      width_lat <= width_eff;
    end else begin
      case (phase)
        ST_WAIT: begin
          if (cnt == ONE) begin
            phase <= ST_ON;
            cnt   <= width_lat;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        ST_ON: begin
          if (cnt == ONE) phase <= ST_IDLE;
          else cnt <= cnt - ONE;
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

  logic [CNT_W:0] run_len;
  always_ff @(posedge clk) begin
    if (!rst_n) run_len <= '0;
    else if (clamp_out && !trail) run_len <= run_len + 1'b1;
    else run_len <= '0;
  end

  p_reset_low_r1: assert property (@(posedge clk) !rst_n |=> !clamp_out);
  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n) trail |=> !clamp_out);
  p_min_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clamp_out) |-> !$past(trail));
  p_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_out && !trail) |=> (clamp_out || (run_len == {1'b0, width_lat})));
  p_no_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_out |-> (run_len < {1'b0, width_lat}));
  p_width_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    width_lat != '0);

endmodule

// File: tb/tb_hsync_clamp_gen.sv
`timescale 1ns/1ps
module tb_hsync_clamp_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hs_in = 1'b0;
  logic       hs_low_act = 1'b0;
  logic [7:0] place_cfg = 8'd8;
  logic [7:0] width_cfg = 8'd20;
  logic       clamp_out;

  int n_tests = 0;
  int n_fail  = 0;
  int model_fail_prints = 0;
  bit model_on = 1'b0;

  always #5 clk = ~clk;

  hsync_clamp_gen dut (.*);

  // reference model, written from the requirements
  bit m1, m2, m3;
  int mph, mcnt, mw;
  always @(posedge clk) begin
    bit tr;
    if (!rst_n) begin
      m1 = 0; m2 = 0; m3 = 0; mph = 0; mcnt = 0; mw = 1;
    end else begin
      tr = m3 & ~m2;
      m3 = m2; m2 = m1; m1 = hs_in ^ hs_low_act;
      if (tr) begin
        mph = 1; mcnt = (place_cfg == 0) ? 1 : place_cfg;
        mw = (width_cfg == 0) ? 1 : width_cfg;
      end else if (mph == 1) begin
        if (mcnt == 1) begin mph = 2; mcnt = mw; end else mcnt--;
      end else if (mph == 2) begin
        if (mcnt == 1) mph = 0; else mcnt--;
      end
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      n_tests++;
      if (clamp_out !== (mph == 2)) begin
        n_fail++;
        if (model_fail_prints < 10)
          $display("FAIL R3 or R4 or R7 (model) t=%0t actual=%0b expected=%0b", $time, clamp_out, (mph == 2));
        model_fail_prints++;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(int v);
    return (v == 0) ? 1 : v;
  endfunction

  // drive one line; optionally rewrite config after capture; measure rise delay and width
  task automatic line(bit pol, int n, int m, int act_len, bit scramble, string tag);
    int c = 0, w = 0;
    hs_low_act = pol;
    place_cfg = 8'(n); width_cfg = 8'(m);
    hs_in = ~pol;
    repeat (act_len) begin
      @(negedge clk);
      if (act_len == 6) check("R8", clamp_out, 0);
    end
    hs_in = pol;
    while (!clamp_out && c < 600) begin
      @(negedge clk); c++;
      if (scramble && c == 4) begin place_cfg = 8'(n + 37); width_cfg = 8'(m + 11); end
    end
    check({tag, " R3 rise"}, c, 3 + eff(n));
    while (clamp_out && w < 600) begin @(negedge clk); w++; end
    check({tag, " R4 width"}, w, eff(m));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R1 clamp in reset", clamp_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 clamp after reset", clamp_out, 0);

    line(0, 8, 20, 6, 0, "R2 active-high default");
    line(1, 8, 20, 6, 0, "R2 active-low default");
    line(0, 1, 1, 4, 0, "R3 minimum");
    line(0, 0, 5, 4, 0, "R5 zero place");
    line(1, 7, 0, 4, 0, "R5 zero width");
    line(0, 255, 255, 3, 0, "R3 maximum");
    line(0, 9, 6, 5, 1, "R6 config change");
    line(1, 12, 3, 5, 1, "R6 config change low");

    // R7: retrigger during wait, then during pulse, checked by model
    model_on = 1'b1;
    hs_low_act = 0; place_cfg = 8'd10; width_cfg = 8'd10;
    hs_in = 1; repeat (3) @(negedge clk); hs_in = 0;
    repeat (6) @(negedge clk); hs_in = 1; repeat (2) @(negedge clk); hs_in = 0;
    repeat (16) @(negedge clk); hs_in = 1; repeat (2) @(negedge clk); hs_in = 0;
    repeat (4) @(negedge clk);
    check("R7 aborted pulse low", clamp_out, 0);
    repeat (30) @(negedge clk);

    // random lines mixed polarity and settings
    for (int i = 0; i < 400; i++) begin
      hs_low_act = 1'($urandom_range(0, 1));
      hs_in = ~hs_low_act;
      place_cfg = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 2)) : 8'($urandom_range(0, 40));
      width_cfg = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 2)) : 8'($urandom_range(0, 40));
      repeat ($urandom_range(1, 8)) @(negedge clk);
      hs_in = hs_low_act;
      repeat ($urandom_range(1, 60)) begin
        @(negedge clk);
        if ($urandom_range(0, 9) == 0) width_cfg = 8'($urandom);
      end
    end
    repeat (100) @(negedge clk);
    model_on = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule